// File: doc/BRIEF.md
# Emulation Suspend Quiesce Controller

This block decides how a packet-based serial peripheral responds when a debugger asserts its emulation-suspend input. A two-bit control register selects between free-run, where suspend is ignored, and a graceful stop. Graceful stop holds each traffic path at its next packet boundary. Three paths are tracked on their own: outbound DMA, master-side transmit and inbound receive. Each has a small state machine with the states RUN, DRAIN and HELD.

The named transitions are:
- RUN→DRAIN on halt while the path is busy.
- RUN→HELD on halt while the path is idle.
- DRAIN→HELD when the path goes idle under halt.
- HELD→DRAIN when new inbound work appears under halt.
- DRAIN→RUN and HELD→RUN as soon as halt drops.

While halted, the block closes the gates for new DMA packets, new transmit requests and new interrupts for newly arriving packets. Work already in progress runs to completion. The slave side keeps accepting inbound packets until its buffers are full, and then answers with retry. The control register can be read and written at all times, including while the rest of the peripheral is held. A quiesced flag reports when every path has reached HELD.

Top module: `emu_quiesce_ctrl`

## Requirements
- R1: The control register has FREE at bit 0 and SOFT at bit 1, and resets to 2'b01. A write with `ctl_we` high loads `ctl_wdata` at the clock edge. `ctl_rdata` always shows the register, including while suspended.
- R2: While FREE is 1, suspend has no effect. In the following cycle, all three start gates are 1, `rx_retry` is 0 and `quiesced` is 0.
- R3: Halt is sampled as `suspend_in` high with FREE 0, whatever the value of SOFT. Both SOFT values give the graceful stop.
- R4: In the cycle after halt is sampled, `dma_start_ok`, `tx_start_ok` and `irq_new_ok` are 0. They stay 0 for as long as halt continues to be sampled.
- R5: A path that is busy when halt arrives goes to DRAIN and stays there while it is busy. It goes to HELD in the cycle after it is sampled idle under halt.
- R6: While halt is registered, `rx_accept` is the inverse of `rx_buf_full` and `rx_retry` equals `rx_buf_full`, with no delay. Otherwise `rx_accept` is 1 and `rx_retry` is 0.
- R7: `quiesced` is 1 exactly when all three paths are HELD. Inbound activity on `rx_busy` while HELD returns the receive path to DRAIN on the next edge.
- R8: When halt stops being sampled, all start gates are 1 and `quiesced` is 0 in the next cycle. This holds even if a path was still draining.
- R9: After reset, all start gates and `rx_accept` are 1, and `rx_retry` and `quiesced` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data (bit 1 SOFT, bit 0 FREE) |
| ctl_rdata | output | 2 | Control register contents |
| suspend_in | input | 1 | Emulation suspend request |
| dma_busy | input | 1 | DMA packet in progress |
| tx_busy | input | 1 | Transmit packet in progress, including physical-layer buffered packets |
| rx_busy | input | 1 | Inbound packet in progress |
| rx_buf_full | input | 1 | No inbound buffer free |
| dma_start_ok | output | 1 | New DMA packet may start |
| tx_start_ok | output | 1 | New master-side request may start |
| irq_new_ok | output | 1 | Interrupts for newly arriving packets allowed |
| rx_accept | output | 1 | Inbound packet may be accepted |
| rx_retry | output | 1 | Inbound packet must be answered with retry |
| quiesced | output | 1 | All paths held at a packet boundary |

## Verification
The bench releases suspend partway through a drain. A design that waits for the drain to finish would keep its gates shut for extra cycles. It keeps a path busy across many halted cycles and then drops the busy flag. A design that skips DRAIN would report `quiesced` early, and one that never leaves DRAIN would never report it. It writes the control register while suspended and tries both SOFT values. A design that blocks register access or treats SOFT=0 as a hard freeze would diverge from the model. Random receive traffic while HELD checks that `quiesced` drops when inbound work reappears, and that retry appears only when the buffer is full under halt.

// File: rtl/qc_pkg.sv
package qc_pkg;
    localparam int CTL_W      = 2;
    localparam int FREE_BIT   = 0;
    localparam int SOFT_BIT   = 1;
    localparam int NUM_PATHS  = 3;
    localparam int P_DMA      = 0;
    localparam int P_TX       = 1;
    localparam int P_RX       = 2;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_DRAIN = 2'd1,
        PS_HELD  = 2'd2
    } path_st_e;
endpackage

// File: rtl/qc_ctl_reg.sv
module qc_ctl_reg
    import qc_pkg::*;
#(
    parameter logic [CTL_W-1:0] RST_VAL = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output logic             free_run
);
    logic [CTL_W-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ctl_q <= RST_VAL;
        else if (we) ctl_q <= wdata;
    end

    assign rdata    = ctl_q;
    assign free_run = ctl_q[FREE_BIT];

    // R1
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rdata == $past(wdata));
endmodule

// File: rtl/qc_path_fsm.sv
module qc_path_fsm
    import qc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     halt,
    input  logic     busy,
    output path_st_e st,
    output logic     open_o,
    output logic     held_o
);
    path_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_RUN:   if (halt) st_d = busy ? PS_DRAIN : PS_HELD;
            PS_DRAIN: if (!halt) st_d = PS_RUN;
                      else if (!busy) st_d = PS_HELD;
            PS_HELD:  if (!halt) st_d = PS_RUN;
                      else if (busy) st_d = PS_DRAIN;
            default:  st_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        open_o = 1'b0;
        held_o = 1'b0;
        unique case (st_q)
            PS_RUN:   open_o = 1'b1;
            PS_DRAIN: ;
            PS_HELD:  held_o = 1'b1;
            default:  open_o = 1'b1;
        endcase
    end

    assign st = st_q;

    // R5
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_DRAIN && halt && busy) |=> st_q == PS_DRAIN);

    // R5
    drain_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_DRAIN && halt && !busy) |=> held_o);

    // R8
    reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> open_o);
endmodule

// File: rtl/emu_quiesce_ctrl.sv
module emu_quiesce_ctrl
    import qc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [1:0] ctl_wdata,
    output logic [1:0] ctl_rdata,
    input  logic       suspend_in,
    input  logic       dma_busy,
    input  logic       tx_busy,
    input  logic       rx_busy,
    input  logic       rx_buf_full,
    output logic       dma_start_ok,
    output logic       tx_start_ok,
    output logic       irq_new_ok,
    output logic       rx_accept,
    output logic       rx_retry,
    output logic       quiesced
);
    logic                 free_run;
    logic                 halt;
    logic                 halt_q;
    logic [NUM_PATHS-1:0] busy_v;
    logic [NUM_PATHS-1:0] open_v;
    logic [NUM_PATHS-1:0] held_v;
    path_st_e             st_v [NUM_PATHS];

    qc_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .rdata    (ctl_rdata),
        .free_run (free_run)
    );

    // Hard stop is unsupported: SOFT=0 and SOFT=1 both give the graceful stop.
    assign halt = suspend_in & ~free_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= halt;
    end

    assign busy_v[P_DMA] = dma_busy;
    assign busy_v[P_TX]  = tx_busy;
    assign busy_v[P_RX]  = rx_busy;

    for (genvar i = 0; i < NUM_PATHS; i++) begin : g_path
        qc_path_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .halt   (halt),
            .busy   (busy_v[i]),
            .st     (st_v[i]),
            .open_o (open_v[i]),
            .held_o (held_v[i])
        );
    end

    assign dma_start_ok = open_v[P_DMA];
    assign tx_start_ok  = open_v[P_TX];
    assign irq_new_ok   = ~halt_q;
    assign rx_retry     = halt_q & rx_buf_full;
    assign rx_accept    = ~rx_retry;
    assign quiesced     = &held_v;

    // R4
    gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |-> (!dma_start_ok && !tx_start_ok && !irq_new_ok));

    // R6
    retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_retry |-> (!rx_accept && rx_buf_full && halt_q));

    // R2
    free_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_run |=> (dma_start_ok && tx_start_ok && irq_new_ok && !quiesced));

    // R7
    quiesced_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiesced |-> (halt_q && st_v[P_RX] == PS_HELD));
endmodule

// File: tb/tb_emu_quiesce_ctrl.sv
`timescale 1ns/1ps
module tb_emu_quiesce_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 1'b0;
    logic [1:0] ctl_wdata = 2'b00;
    logic [1:0] ctl_rdata;
    logic suspend_in = 1'b0, dma_busy = 1'b0, tx_busy = 1'b0, rx_busy = 1'b0, rx_buf_full = 1'b0;
    logic dma_start_ok, tx_start_ok, irq_new_ok, rx_accept, rx_retry, quiesced;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model: 0 run, 1 drain, 2 held.
    logic [1:0] m_ctl;
    logic       m_hq;
    int         m_st [3];

    always #5 clk = ~clk;

    emu_quiesce_ctrl dut (.*);

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic m_open(int p);
        return m_st[p] == 0;
    endfunction

    function automatic logic m_quiet();
        return m_st[0] == 2 && m_st[1] == 2 && m_st[2] == 2;
    endfunction

    function automatic int m_next(int s, logic h, logic b);
        case (s)
            0: return h ? (b ? 1 : 2) : 0;
            1: return !h ? 0 : (b ? 1 : 2);
            default: return !h ? 0 : (b ? 1 : 2);
        endcase
    endfunction

    task automatic m_reset();
        m_ctl = 2'b01;
        m_hq = 1'b0;
        for (int i = 0; i < 3; i++) m_st[i] = 0;
    endtask

    // One clock: inputs are already driven; update the model at the edge, sample after it.
    task automatic step();
        logic h;
        logic [2:0] b;
        h = suspend_in && !m_ctl[0];
        b = {rx_busy, tx_busy, dma_busy};
        @(posedge clk);
        for (int i = 0; i < 3; i++) m_st[i] = m_next(m_st[i], h, b[i]);
        m_hq = h;
        if (ctl_we) m_ctl = ctl_wdata;
        #1;
    endtask

    task automatic cmp_all(string tag);
        n_chk++;
        if (ctl_rdata !== m_ctl) begin
            n_fail++;
            $display("FAIL R1 ctl_rdata actual=%0b expected=%0b", ctl_rdata, m_ctl);
        end
        chk(tag, "dma_start_ok", dma_start_ok, m_open(0));
        chk(tag, "tx_start_ok", tx_start_ok, m_open(1));
        chk(tag, "irq_new_ok", irq_new_ok, !m_hq);
        chk(tag, "rx_accept", rx_accept, !(m_hq && rx_buf_full));
        chk(tag, "rx_retry", rx_retry, m_hq && rx_buf_full);
        chk(tag, "quiesced", quiesced, m_quiet());
    endtask

    task automatic drive(logic s, logic d, logic t, logic r, logic f);
        @(negedge clk);
        ctl_we = 1'b0;
        suspend_in = s; dma_busy = d; tx_busy = t; rx_busy = r; rx_buf_full = f;
    endtask

    task automatic wr_ctl(logic [1:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        step();
        cmp_all("R1");
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        m_reset();
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9", "dma_start_ok", dma_start_ok, 1'b1);
        chk("R9", "tx_start_ok", tx_start_ok, 1'b1);
        chk("R9", "rx_accept", rx_accept, 1'b1);
        chk("R9", "rx_retry", rx_retry, 1'b0);
        chk("R9", "quiesced", quiesced, 1'b0);
        n_chk++;
        if (ctl_rdata !== 2'b01) begin
            n_fail++;
            $display("FAIL R1 reset ctl_rdata actual=%0b expected=01", ctl_rdata);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: free run ignores suspend
        drive(1, 1, 1, 1, 1);
        repeat (4) begin step(); cmp_all("R2"); end
        chk("R2", "dma_start_ok", dma_start_ok, 1'b1);
        chk("R2", "rx_retry", rx_retry, 1'b0);

        // R3: SOFT=1, FREE=0 halts; tx path busy drains (R5)
        wr_ctl(2'b10);
        drive(1, 0, 1, 0, 0);
        step(); cmp_all("R4");
        chk("R4", "tx_start_ok", tx_start_ok, 1'b0);
        chk("R3", "irq_new_ok", irq_new_ok, 1'b0);
        repeat (5) begin step(); cmp_all("R5"); end
        chk("R5", "quiesced", quiesced, 1'b0);
        drive(1, 0, 0, 0, 1);
        step(); cmp_all("R5");
        chk("R5", "quiesced", quiesced, 1'b1);
        chk("R6", "rx_retry", rx_retry, 1'b1);
        // R1: register writes keep working while held
        wr_ctl(2'b00);
        // R7: inbound activity while held
        drive(1, 0, 0, 1, 0);
        step(); cmp_all("R7");
        chk("R7", "quiesced", quiesced, 1'b0);
        chk("R6", "rx_accept", rx_accept, 1'b1);
        // R3: SOFT=0 also soft stop; R8: release mid-drain
        drive(1, 1, 0, 0, 0);
        repeat (3) begin step(); cmp_all("R3"); end
        drive(0, 1, 0, 0, 0);
        step(); cmp_all("R8");
        chk("R8", "dma_start_ok", dma_start_ok, 1'b1);
        // R2: setting FREE during suspend reopens
        drive(1, 1, 1, 0, 0);
        step(); cmp_all("R4");
        wr_ctl(2'b01);
        step(); cmp_all("R2");
        chk("R2", "tx_start_ok", tx_start_ok, 1'b1);

        // Random phase
        seed = 1234;
        void'($urandom(seed));
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) suspend_in = ~suspend_in;
            if ($urandom_range(0, 3) == 0) dma_busy = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) tx_busy = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) rx_busy = $urandom_range(0, 1);
            rx_buf_full = ($urandom_range(0, 2) == 0);
            ctl_we = ($urandom_range(0, 39) == 0);
            ctl_wdata = ($urandom_range(0, 3) == 0) ? 2'b01 : 2'($urandom_range(0, 3)) & 2'b10;
            step();
            cmp_all("R4 R6 R7");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule